// File: doc/BRIEF.md
# Timekeeping Counters with Alarm Interrupts

This block keeps three free-running binary counters: a 40-bit real-time clock, a 40-bit interval timer and a 32-bit event counter. The clock and the timer advance on a 256 Hz tick-enable input, so their lowest byte counts 1/256 s fractions. The event counter advances once for each qualified falling edge of an already synchronised line-activity input. Each counter has an alarm register of its own width. When a counter becomes equal to its alarm, a flag is set. When a flag is set and its active-low enable is 0, the active-low interrupt output is pulled low.

The line qualifier is a four-state machine clocked by a separate 1 kHz tick-enable. Its states are `Q_LOW` (line accepted as low), `Q_RISE` (line high, waiting out the delay), `Q_HIGH` (line accepted as high) and `Q_FALL` (line low, waiting out the delay). It has these transitions:
- `Q_LOW`→`Q_RISE` when the line reads high.
- `Q_RISE`→`Q_LOW` when the line drops before the delay ends.
- `Q_RISE`→`Q_HIGH` when the delay expires.
- `Q_HIGH`→`Q_FALL` when the line reads low. This transition is the event that advances the event counter.
- `Q_FALL`→`Q_HIGH` when the line returns high early.
- `Q_FALL`→`Q_LOW` when the delay expires.

In automatic mode the interval timer runs while the qualifier is in `Q_HIGH` or `Q_FALL`.

Software uses a byte-wide register port. The address map is: 0 status, 1 control, 2–6 clock, 7–11 clock alarm, 12–16 timer, 17–21 timer alarm, 22–25 event counter, 26–29 event alarm. Multi-byte values are least significant byte first. Counter reads return holding registers, which are loaded only by a snapshot strobe.

Top module: `tk_timekeeper`

## Requirements
- R1: After reset all counters, alarms and holding registers are 0, status reads 0x38, control reads 0x00 and `irq_n` is 1.
- R2: With control bit 4 (oscillator enable) at 1, each `tick_256` pulse advances the clock by one, wrapping at 2^40.
- R3: With control bit 4 at 0, no counter changes except by a register write.
- R4: In manual mode (control bit 5 = 0), the interval timer advances on `tick_256` while control bit 6 is 0 and holds while it is 1.
- R5: In automatic mode (control bit 5 = 1), the interval timer advances on `tick_256` only while the qualifier is in `Q_HIGH` or `Q_FALL`, and control bit 6 has no effect. A state change is accepted on the `tick_1k` pulse that completes the delay count while the line holds its new level.
- R6: Control bit 7 selects the delay: 1 gives 123 `tick_1k` pulses and 0 gives 4.
- R7: With control bit 4 at 1, the event counter advances by one in the cycle in which the line reads low while the qualifier is in `Q_HIGH`. A high pulse shorter than the delay is not counted.
- R8: When a counter changes to equal its alarm register, or the alarm changes to equal it, status bit 0 (clock), bit 1 (timer) or bit 2 (event) is set one cycle later.
- R9: Status bits 3, 4 and 5 are active-low enables for flags 0, 1 and 2. `irq_n` is 0 exactly while some flag is 1 and its enable is 0.
- R10: A read of address 0 returns the flags as they were and clears them. A flag raised in that same cycle is kept.
- R11: Counter addresses read the holding registers. `snap` copies all three counters into them, and they are otherwise unchanged.
- R12: A write sets one byte of a counter, an alarm, the enables (status bits 5:3) or control bits 7:4. A counter byte write takes priority over an increment in that cycle. Read data appears in `reg_rdata` one clock after `reg_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_256 | input | 1 | 256 Hz advance enable, one cycle wide |
| tick_1k | input | 1 | 1 kHz enable for the delay count |
| line_in | input | 1 | Synchronised line-activity level |
| snap | input | 1 | Copy counters into holding registers |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, registered |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The hardest case to reach is a status read that lands in the same cycle as a new alarm flag: the clear must not swallow the flag. With the oscillator off, the bench leaves an older flag set. It then writes the last clock byte so that the clock equals its alarm, and issues a status read in the very next cycle. The first read must return the old flag, and a second read must show the clock flag. Long-delay qualification, and glitches just shorter than the delay, are reached by holding the line for chosen numbers of `tick_1k` pulses.

// File: rtl/tk_pkg.sv
package tk_pkg;
    typedef enum logic [1:0] {
        Q_LOW  = 2'd0,
        Q_RISE = 2'd1,
        Q_HIGH = 2'd2,
        Q_FALL = 2'd3
    } qual_state_t;

    // positions inside the stored control nibble (register bits 7:4)
    localparam int CTL_OSC  = 0;
    localparam int CTL_AUTO = 1;
    localparam int CTL_STOP = 2;
    localparam int CTL_LONG = 3;

    localparam int N_ALARM = 3;
endpackage

// File: rtl/tk_line_qual.sv
module tk_line_qual
    import tk_pkg::*;
#(
    parameter int LONG_DLY  = 123,
    parameter int SHORT_DLY = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line,
    input  logic tick_ms,
    input  logic long_sel,
    output logic qual_high,
    output logic fall_pulse
);
    localparam int CW = $clog2(LONG_DLY + 1);

    qual_state_t state, state_n;
    logic [CW-1:0] cnt, cnt_n, lim;
    logic          done;

    assign lim  = long_sel ? CW'(LONG_DLY) : CW'(SHORT_DLY);
    assign done = tick_ms && ((cnt + CW'(1)) >= lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= Q_LOW;
            cnt   <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
        end
    end

    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        unique case (state)
            Q_LOW: begin
                if (line) begin
                    state_n = Q_RISE;
                    cnt_n   = '0;
                end
            end
            Q_RISE: begin
                if (!line) begin
                    state_n = Q_LOW;
                end else if (done) begin
                    state_n = Q_HIGH;
                    cnt_n   = '0;
                end else if (tick_ms) begin
                    cnt_n = cnt + CW'(1);
                end
            end
            Q_HIGH: begin
                if (!line) begin
                    state_n = Q_FALL;
                    cnt_n   = '0;
                end
            end
            Q_FALL: begin
                if (line) begin
                    state_n = Q_HIGH;
                end else if (done) begin
                    state_n = Q_LOW;
                    cnt_n   = '0;
                end else if (tick_ms) begin
                    cnt_n = cnt + CW'(1);
                end
            end
        endcase
    end

    always_comb begin
        qual_high  = (state == Q_HIGH) || (state == Q_FALL);
        fall_pulse = (state == Q_HIGH) && !line;
    end

    // R6
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(LONG_DLY));

    // R7
    fall_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall_pulse |=> (state == Q_FALL));

    // R5
    rise_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == Q_LOW && line) |=> !qual_high);
endmodule

// File: rtl/tk_counter.sv
module tk_counter #(
    parameter int W = 40
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      inc,
    input  logic                      snap,
    input  logic                      cnt_we,
    input  logic                      alm_we,
    input  logic [$clog2(W/8)-1:0]    bidx,
    input  logic [7:0]                wdata,
    output logic [W-1:0]              hold,
    output logic [W-1:0]              alarm,
    output logic                      hit
);
    localparam int NB = W / 8;
    localparam int BW = $clog2(NB);

    logic [W-1:0] cnt, cnt_n, alm_n;
    logic         eq_q;

    always_comb begin
        cnt_n = cnt;
        alm_n = alarm;
        if (cnt_we) begin
            for (int i = 0; i < NB; i++)
                if (bidx == BW'(i)) cnt_n[i*8 +: 8] = wdata;
        end else if (inc) begin
            cnt_n = cnt + W'(1);
        end
        if (alm_we) begin
            for (int i = 0; i < NB; i++)
                if (bidx == BW'(i)) alm_n[i*8 +: 8] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            alarm <= '0;
            hold  <= '0;
            eq_q  <= 1'b1;
        end else begin
            cnt   <= cnt_n;
            alarm <= alm_n;
            eq_q  <= (cnt == alarm);
            if (snap) hold <= cnt;
        end
    end

    assign hit = (cnt == alarm) && !eq_q;

    // R2
    inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !cnt_we) |=> (cnt == $past(cnt) + W'(1)));

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !cnt_we) |=> $stable(cnt));

    // R11
    snap_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snap |=> (hold == $past(cnt)));

    // R11
    hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !snap |=> $stable(hold));
endmodule

// File: rtl/tk_timekeeper.sv
module tk_timekeeper
    import tk_pkg::*;
#(
    parameter int RTC_W     = 40,
    parameter int IT_W      = 40,
    parameter int CC_W      = 32,
    parameter int ADDR_W    = 5,
    parameter int LONG_DLY  = 123,
    parameter int SHORT_DLY = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_256,
    input  logic              tick_1k,
    input  logic              line_in,
    input  logic              snap,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              irq_n
);
    localparam int RTC_B  = RTC_W / 8;
    localparam int IT_B   = IT_W / 8;
    localparam int CC_B   = CC_W / 8;
    localparam int RTC_BW = $clog2(RTC_B);
    localparam int IT_BW  = $clog2(IT_B);
    localparam int CC_BW  = $clog2(CC_B);
    localparam int A_STAT = 0;
    localparam int A_CTL  = 1;
    localparam int A_RTC  = 2;
    localparam int A_RTCA = A_RTC + RTC_B;
    localparam int A_IT   = A_RTCA + RTC_B;
    localparam int A_ITA  = A_IT + IT_B;
    localparam int A_CC   = A_ITA + IT_B;
    localparam int A_CCA  = A_CC + CC_B;

    function automatic logic in_rng(input logic [ADDR_W-1:0] a, input int lo, input int n);
        return (int'(a) >= lo) && (int'(a) < lo + n);
    endfunction

    function automatic logic [ADDR_W-1:0] rel_of(input logic [ADDR_W-1:0] a, input int lo);
        return ADDR_W'(int'(a) - lo);
    endfunction

    logic [3:0]         ctl;
    logic [N_ALARM-1:0] flags, en_n, hits;
    logic               qual_high, fall_pulse;
    logic               rtc_inc, it_inc, cc_inc;
    logic [RTC_W-1:0]   rtc_hold, rtc_alm;
    logic [IT_W-1:0]    it_hold, it_alm;
    logic [CC_W-1:0]    cc_hold, cc_alm;
    logic               rtc_cw, rtc_aw, it_cw, it_aw, cc_cw, cc_aw;
    logic [ADDR_W-1:0]  rtc_rel, it_rel, cc_rel;
    logic [7:0]         rd_val;
    logic               stat_rd;

    tk_line_qual #(.LONG_DLY(LONG_DLY), .SHORT_DLY(SHORT_DLY)) u_qual (
        .clk       (clk),
        .rst_n     (rst_n),
        .line      (line_in),
        .tick_ms   (tick_1k),
        .long_sel  (ctl[CTL_LONG]),
        .qual_high (qual_high),
        .fall_pulse(fall_pulse)
    );

    always_comb begin
        rtc_inc = ctl[CTL_OSC] && tick_256;
        it_inc  = ctl[CTL_OSC] && tick_256 &&
                  (ctl[CTL_AUTO] ? qual_high : !ctl[CTL_STOP]);
        cc_inc  = ctl[CTL_OSC] && fall_pulse;
    end

    always_comb begin
        rtc_cw  = reg_wr && in_rng(reg_addr, A_RTC,  RTC_B);
        rtc_aw  = reg_wr && in_rng(reg_addr, A_RTCA, RTC_B);
        it_cw   = reg_wr && in_rng(reg_addr, A_IT,   IT_B);
        it_aw   = reg_wr && in_rng(reg_addr, A_ITA,  IT_B);
        cc_cw   = reg_wr && in_rng(reg_addr, A_CC,   CC_B);
        cc_aw   = reg_wr && in_rng(reg_addr, A_CCA,  CC_B);
        rtc_rel = in_rng(reg_addr, A_RTCA, RTC_B) ? rel_of(reg_addr, A_RTCA) : rel_of(reg_addr, A_RTC);
        it_rel  = in_rng(reg_addr, A_ITA,  IT_B)  ? rel_of(reg_addr, A_ITA)  : rel_of(reg_addr, A_IT);
        cc_rel  = in_rng(reg_addr, A_CCA,  CC_B)  ? rel_of(reg_addr, A_CCA)  : rel_of(reg_addr, A_CC);
    end

    tk_counter #(.W(RTC_W)) u_rtc (
        .clk(clk), .rst_n(rst_n), .inc(rtc_inc), .snap(snap),
        .cnt_we(rtc_cw), .alm_we(rtc_aw), .bidx(rtc_rel[RTC_BW-1:0]),
        .wdata(reg_wdata), .hold(rtc_hold), .alarm(rtc_alm), .hit(hits[0])
    );

    tk_counter #(.W(IT_W)) u_it (
        .clk(clk), .rst_n(rst_n), .inc(it_inc), .snap(snap),
        .cnt_we(it_cw), .alm_we(it_aw), .bidx(it_rel[IT_BW-1:0]),
        .wdata(reg_wdata), .hold(it_hold), .alarm(it_alm), .hit(hits[1])
    );

    tk_counter #(.W(CC_W)) u_cc (
        .clk(clk), .rst_n(rst_n), .inc(cc_inc), .snap(snap),
        .cnt_we(cc_cw), .alm_we(cc_aw), .bidx(cc_rel[CC_BW-1:0]),
        .wdata(reg_wdata), .hold(cc_hold), .alarm(cc_alm), .hit(hits[2])
    );

    always_comb begin
        rd_val = 8'h00;
        if (reg_addr == ADDR_W'(A_STAT))
            rd_val = {2'b00, en_n, flags};
        else if (reg_addr == ADDR_W'(A_CTL))
            rd_val = {ctl, 4'b0000};
        else if (in_rng(reg_addr, A_RTC, RTC_B))
            rd_val = 8'(rtc_hold >> {rtc_rel, 3'b000});
        else if (in_rng(reg_addr, A_RTCA, RTC_B))
            rd_val = 8'(rtc_alm >> {rtc_rel, 3'b000});
        else if (in_rng(reg_addr, A_IT, IT_B))
            rd_val = 8'(it_hold >> {it_rel, 3'b000});
        else if (in_rng(reg_addr, A_ITA, IT_B))
            rd_val = 8'(it_alm >> {it_rel, 3'b000});
        else if (in_rng(reg_addr, A_CC, CC_B))
            rd_val = 8'(cc_hold >> {cc_rel, 3'b000});
        else if (in_rng(reg_addr, A_CCA, CC_B))
            rd_val = 8'(cc_alm >> {cc_rel, 3'b000});
    end

    assign stat_rd = reg_rd && (reg_addr == ADDR_W'(A_STAT));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags     <= '0;
            en_n      <= '1;
            ctl       <= '0;
            reg_rdata <= '0;
        end else begin
            flags <= stat_rd ? hits : (flags | hits);
            if (reg_wr && reg_addr == ADDR_W'(A_STAT)) en_n <= reg_wdata[5:3];
            if (reg_wr && reg_addr == ADDR_W'(A_CTL))  ctl  <= reg_wdata[7:4];
            if (reg_rd) reg_rdata <= rd_val;
        end
    end

    assign irq_n = ~|(flags & ~en_n);

    // R10
    hit_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|hits) |=> (|flags));

    // R10
    rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && hits == '0) |=> (flags == '0));

    // R9
    irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(hits & ~en_n)) |=> !irq_n);
endmodule

// File: tb/sim_tk_timekeeper.sv
module sim_tk_timekeeper;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_256 = 1'b0, tick_1k = 1'b0, line_in = 1'b0, snap = 1'b0;
    logic       reg_rd = 1'b0, reg_wr = 1'b0;
    logic [4:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq_n;

    always #5 clk = ~clk;

    tk_timekeeper u0 (
        .clk(clk), .rst_n(rst_n), .tick_256(tick_256), .tick_1k(tick_1k),
        .line_in(line_in), .snap(snap), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_n(irq_n)
    );

    int  vectors = 0, fails = 0;
    int  cyc = 0;
    bit  t256_en = 0, started = 0;

    // reference model state
    longint m_cnt[3], m_alm[3], m_hold[3];
    bit     m_eq[3];
    bit [2:0] m_flags, m_en;
    bit [3:0] m_ctl;
    bit       m_qual, m_pend;
    int       m_qcnt;
    bit [7:0] m_rdata;
    int W[3]  = '{40, 40, 32};
    int CB[3] = '{2, 12, 22};
    int AB[3] = '{7, 17, 26};

    function automatic longint msk(int k);
        return (64'd1 << W[k]) - 1;
    endfunction

    function automatic bit [7:0] m_read(int a);
        if (a == 0) return {2'b00, m_en, m_flags};
        if (a == 1) return {m_ctl, 4'b0000};
        for (int k = 0; k < 3; k++) begin
            if (a >= CB[k] && a < CB[k] + W[k]/8) return 8'((m_hold[k] >> (8*(a-CB[k]))) & 255);
            if (a >= AB[k] && a < AB[k] + W[k]/8) return 8'((m_alm[k] >> (8*(a-AB[k]))) & 255);
        end
        return 8'h00;
    endfunction

    always @(posedge clk) begin : model
        bit [2:0] hit;
        bit [3:0] octl;
        bit       pulse;
        bit       inc[3];
        int       dly;
        int       a;
        if (!rst_n) begin
            for (int k = 0; k < 3; k++) begin
                m_cnt[k] = 0; m_alm[k] = 0; m_hold[k] = 0; m_eq[k] = 1;
            end
            m_flags = 0; m_en = 3'b111; m_ctl = 0; m_qual = 0; m_pend = 0;
            m_qcnt = 0; m_rdata = 0;
        end else begin
            octl = m_ctl;
            a = int'(reg_addr);
            for (int k = 0; k < 3; k++) begin
                hit[k]  = (m_cnt[k] == m_alm[k]) && !m_eq[k];
                m_eq[k] = (m_cnt[k] == m_alm[k]);
            end
            pulse  = m_qual && !m_pend && !line_in;
            inc[0] = octl[0] && tick_256;
            inc[1] = octl[0] && tick_256 && (octl[1] ? m_qual : !octl[2]);
            inc[2] = octl[0] && pulse;
            if (reg_rd) m_rdata = m_read(a);
            if (reg_rd && a == 0) m_flags = 0;
            m_flags |= hit;
            if (snap) for (int k = 0; k < 3; k++) m_hold[k] = m_cnt[k];
            for (int k = 0; k < 3; k++) begin
                if (reg_wr && a >= CB[k] && a < CB[k] + W[k]/8) begin
                    m_cnt[k] &= ~(longint'(255) << (8*(a-CB[k])));
                    m_cnt[k] |= longint'(reg_wdata) << (8*(a-CB[k]));
                end else if (inc[k]) begin
                    m_cnt[k] = (m_cnt[k] + 1) & msk(k);
                end
                if (reg_wr && a >= AB[k] && a < AB[k] + W[k]/8) begin
                    m_alm[k] &= ~(longint'(255) << (8*(a-AB[k])));
                    m_alm[k] |= longint'(reg_wdata) << (8*(a-AB[k]));
                end
            end
            if (reg_wr && a == 0) m_en = reg_wdata[5:3];
            if (reg_wr && a == 1) m_ctl = reg_wdata[7:4];
            dly = octl[3] ? 123 : 4;
            if (line_in == m_qual) m_pend = 0;
            else if (!m_pend) begin m_pend = 1; m_qcnt = 0; end
            else if (tick_1k) begin
                m_qcnt++;
                if (m_qcnt >= dly) begin m_qual = line_in; m_pend = 0; m_qcnt = 0; end
            end
        end
    end

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    endtask

    // ticks, watchdog, and per-cycle interrupt comparison (R9)
    always @(negedge clk) begin
        cyc++;
        tick_256 = t256_en && (cyc % 3 == 0);
        tick_1k  = (cyc % 4 == 0);
        if (started) begin
            vectors++;
            if (irq_n !== ~|(m_flags & ~m_en)) begin
                fails++;
                $display("FAIL R9: irq_n got %b expected %b", irq_n, ~|(m_flags & ~m_en));
            end
        end
        if (cyc == 150000) begin
            fails++;
            $display("FAIL watchdog: run did not finish");
            summary();
            $finish;
        end
    end

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        reg_wr = 1; reg_addr = 5'(a); reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd(input int a, input string tag);
        reg_rd = 1; reg_addr = 5'(a);
        @(negedge clk);
        reg_rd = 0;
        chk(reg_rdata, m_rdata, tag);
    endtask

    task automatic take_snap();
        snap = 1;
        @(negedge clk);
        snap = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        longint n;
        idle(4);
        rst_n = 1;
        started = 1;
        // R1 reset values
        rd(0, "R1"); chk(reg_rdata, 8'h38, "R1");
        rd(1, "R1"); chk(reg_rdata, 8'h00, "R1");
        rd(2, "R1"); chk(reg_rdata, 8'h00, "R1");
        chk({7'd0, irq_n}, 8'h01, "R1");
        // R2 clock runs, R4 timer runs in manual mode
        wr(1, 8'h10); t256_en = 1;
        idle(60); take_snap();
        for (int i = 0; i < 5; i++) rd(2 + i, "R2");
        for (int i = 0; i < 5; i++) rd(12 + i, "R4");
        // R11 holding register frozen without snap
        idle(30); rd(2, "R11");
        take_snap(); rd(2, "R11");
        // R12 byte writes
        wr(7, 8'hA5); rd(7, "R12");
        wr(3, 8'h12); take_snap(); rd(3, "R12"); rd(2, "R12");
        rd(1, "R12"); chk(reg_rdata, 8'h10, "R12");
        // R3 oscillator off
        wr(1, 8'h00); take_snap(); idle(40); take_snap();
        rd(2, "R3"); rd(12, "R3");
        // R4 stop bit
        wr(1, 8'h50); take_snap(); idle(30); take_snap(); rd(12, "R4");
        wr(1, 8'h10); idle(30); take_snap(); rd(12, "R4");
        // R5 automatic short delay, stop bit ignored
        wr(1, 8'h70); line_in = 0; idle(30); take_snap(); rd(12, "R5");
        line_in = 1; idle(40); take_snap(); rd(12, "R5"); rd(13, "R5");
        line_in = 0; idle(40); take_snap(); rd(12, "R5");
        rd(22, "R7");
        // R6 long delay
        wr(1, 8'hB0); line_in = 1; idle(200); take_snap(); rd(12, "R6");
        idle(400); take_snap(); rd(12, "R6");
        line_in = 0; idle(20); take_snap(); rd(22, "R7");
        // R7 glitch shorter than the long delay
        idle(600);
        line_in = 1; idle(100); line_in = 0; idle(10);
        take_snap(); rd(22, "R7");
        // R8 and R9 event alarm with enable
        wr(1, 8'h30); wr(0, 8'h18);
        n = m_cnt[2] + 1;
        for (int i = 0; i < 4; i++) wr(26 + i, 8'((n >> (8*i)) & 255));
        line_in = 1; idle(30); line_in = 0; idle(5);
        chk({7'd0, irq_n}, 8'h00, "R9");
        rd(0, "R8"); chk(reg_rdata & 8'h04, 8'h04, "R8");
        chk({7'd0, irq_n}, 8'h01, "R10");
        // R10 read colliding with a new flag
        wr(1, 8'h00); wr(0, 8'h38);
        n = m_cnt[2];
        wr(22, 8'((n & 255) ^ 1)); wr(22, 8'(n & 255)); idle(2);
        wr(7, 8'h77);
        for (int i = 1; i < 5; i++) wr(7 + i, 8'h00);
        for (int i = 1; i < 5; i++) wr(2 + i, 8'h00);
        wr(2, 8'h77);
        rd(0, "R10"); chk(reg_rdata & 8'h04, 8'h04, "R10");
        rd(0, "R10"); chk(reg_rdata & 8'h07, 8'h01, "R10");
        rd(0, "R10"); chk(reg_rdata & 8'h07, 8'h00, "R10");
        idle(3);
        summary();
        $finish;
    end
endmodule